// File: doc/BRIEF.md
# Activity-Driven Power-Down Controller

This block watches every signal that can alter a small logic array's result: the dedicated input pins, the bidirectional pins, the external clock pin and the internal feedback nets. It watches them for transitions on a free-running sampling clock. When none of them has moved for a programmable number of sampling cycles, the controller captures the array's live outputs in a hold register, drives the outputs from that register and raises `sleep`. A supply-gating domain can use `sleep` to power the array down.

Any single transition on any monitored signal wakes the controller on the next sampling edge. The outputs then follow the live array again. For a programmable number of cycles after wake-up, `wake_pending` stays high. This models the longer first evaluation that follows a power-down. The controller stays awake until the monitored set has again been quiet for the full interval.

Top module: `pd_ctrl`

## Requirements
- R1: Monitored activity covers all of the following: every bit of `in_pins`, every bit of `io_pins`, `ext_clk` and every bit of `fb_sig`. A toggle of any single one of them wakes a sleeping controller.
- R2: Reset, which is asynchronous and active low, puts the controller awake with `sleep`=0, `wake_pending`=0 and the quiet count cleared. The first sampling edge after reset release only stores a reference sample and is never counted as a quiet cycle.
- R3: An edge that sees a change resets the quiet count. If the next QUIET_CYC sampling edges all see no change, `sleep` goes to 1 right after the last of those edges.
- R4: A change seen on any edge before the interval completes restarts the full QUIET_CYC interval from that edge.
- R5: On the edge where sleep is entered, `out_q` takes the value `live_out` had at that edge. While asleep, `out_q` stays at that value whatever `live_out` does.
- R6: While awake, `out_q` equals `live_out` in the same cycle, with no register in the path.
- R7: While asleep, the first edge that sees a change on the monitored set clears `sleep`.
- R8: `wake_pending` is 1 for exactly WAKE_CYC cycles, starting with the cycle in which `sleep` drops. At all other times it is 0, and it is never 1 while `sleep` is 1.
- R9: After a wake-up, the controller stays awake until a new full quiet interval passes, and then sleeps again.
- R10: Asserting reset while asleep returns the controller at once to the awake state, with `out_q` following `live_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_pins | input | N_IN | Dedicated input pins (monitored) |
| io_pins | input | N_IO | Bidirectional pin levels (monitored) |
| ext_clk | input | 1 | External clock pin level (monitored) |
| fb_sig | input | N_FB | Internal feedback nets (monitored) |
| live_out | input | N_OUT | Current outputs of the logic array |
| out_q | output | N_OUT | Outputs presented to the pins: live while awake, held while asleep |
| sleep | output | 1 | Power-down state indicator |
| wake_pending | output | 1 | Slow first evaluation after wake-up is in progress |

## Verification
The assertions check several properties on every cycle:
- held outputs stay stable while asleep, and the captured value equals the live value at the entry edge;
- outputs pass through while awake;
- a change seen while asleep wakes the controller on the next edge;
- `wake_pending` starts when sleep ends and never overlaps sleep;
- a checker-side count of consecutive quiet edges shows that sleep is entered neither early nor late.

Only the bench's scenarios can show the exact length of the pending window, that each monitored group can cause a wake-up, that the priming edge after reset is not counted, that a late change restarts the interval, and that an asynchronous reset during sleep works.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic {
        PD_AWAKE  = 1'b0,
        PD_ASLEEP = 1'b1
    } pd_mode_e;

    // Counter width able to hold values 0 .. n-1, never below one bit.
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pd_activity_det.sv
module pd_activity_det #(
    parameter int unsigned W = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sample,
    output logic         primed,
    output logic         activity
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic         primed;
    } det_st_t;

    det_st_t      st_d, st_q;
    logic [W-1:0] bit_chg;

    // Per-bit transition detect against the previous sample.
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign bit_chg[g] = sample[g] ^ st_q.prev[g];
    end

    always_comb begin
        st_d        = st_q;
        st_d.prev   = sample;
        st_d.primed = 1'b1;
        primed      = st_q.primed;
        activity    = st_q.primed & (|bit_chg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pd_quiet_timer.sv
module pd_quiet_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic expire
);

    localparam int unsigned CW = pd_pkg::cnt_w(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qt_st_t;

    qt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = run && !clr && (st_q.cnt == LAST);
        if (clr || !run || expire) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pd_wake_timer.sv
module pd_wake_timer #(
    parameter int unsigned LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clr,
    output logic busy
);

    localparam int unsigned CW = pd_pkg::cnt_w(LEN + 1);
    localparam logic [CW-1:0] START = CW'(LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wt_st_t;

    wt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        busy = (st_q.cnt != '0);
        if (clr) begin
            st_d.cnt = '0;
        end else if (load) begin
            st_d.cnt = START;
        end else if (busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pd_hold_bank.sv
module pd_hold_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] val;
    } hb_st_t;

    hb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.val = d;
        end
        q = st_q.val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl #(
    parameter int unsigned N_IN      = 10,
    parameter int unsigned N_IO      = 8,
    parameter int unsigned N_FB      = 8,
    parameter int unsigned N_OUT     = 8,
    parameter int unsigned QUIET_CYC = 4,
    parameter int unsigned WAKE_CYC  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_pins,
    input  logic [N_IO-1:0]  io_pins,
    input  logic             ext_clk,
    input  logic [N_FB-1:0]  fb_sig,
    input  logic [N_OUT-1:0] live_out,
    output logic [N_OUT-1:0] out_q,
    output logic             sleep,
    output logic             wake_pending
);

    import pd_pkg::*;

    localparam int unsigned MON_W = N_IN + N_IO + N_FB + 1;

    typedef struct packed {
        pd_mode_e mode;
    } ctl_st_t;

    ctl_st_t          st_d, st_q;
    logic [MON_W-1:0] mon;
    logic             primed;
    logic             activity;
    logic             expire;
    logic             enter_slp;
    logic             leave_slp;
    logic             awake;
    logic [N_OUT-1:0] held;

    assign mon = {fb_sig, io_pins, ext_clk, in_pins};

    pd_activity_det #(.W(MON_W)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (mon),
        .primed   (primed),
        .activity (activity)
    );

    pd_quiet_timer #(.LIMIT(QUIET_CYC)) u_quiet (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (awake),
        .clr    (activity | ~primed),
        .expire (expire)
    );

    pd_wake_timer #(.LEN(WAKE_CYC)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (leave_slp),
        .clr   (enter_slp),
        .busy  (wake_pending)
    );

    pd_hold_bank #(.W(N_OUT)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (enter_slp),
        .d       (live_out),
        .q       (held)
    );

    always_comb begin
        st_d      = st_q;
        awake     = (st_q.mode == PD_AWAKE);
        enter_slp = awake && expire;
        leave_slp = !awake && activity;
        if (enter_slp) begin
            st_d.mode = PD_ASLEEP;
        end else if (leave_slp) begin
            st_d.mode = PD_AWAKE;
        end
        sleep = !awake;
        out_q = awake ? live_out : held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= PD_AWAKE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pd_ctrl_chk.sv
module pd_ctrl_chk #(
    parameter int unsigned N_IN      = 10,
    parameter int unsigned N_IO      = 8,
    parameter int unsigned N_FB      = 8,
    parameter int unsigned N_OUT     = 8,
    parameter int unsigned QUIET_CYC = 4,
    parameter int unsigned WAKE_CYC  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IN-1:0]  in_pins,
    input logic [N_IO-1:0]  io_pins,
    input logic             ext_clk,
    input logic [N_FB-1:0]  fb_sig,
    input logic [N_OUT-1:0] live_out,
    input logic [N_OUT-1:0] out_q,
    input logic             sleep,
    input logic             wake_pending
);

    localparam int unsigned MON_W = N_IN + N_IO + N_FB + 1;
    localparam int unsigned RW    = $clog2(QUIET_CYC + 2);
    localparam logic [RW-1:0] RMAX = RW'(QUIET_CYC + 1);
    localparam logic [RW-1:0] QLIM = RW'(QUIET_CYC);

    logic [MON_W-1:0] mon;
    logic [MON_W-1:0] ref_m;
    logic             seen;
    logic [RW-1:0]    quiet_run;

    assign mon = {fb_sig, io_pins, ext_clk, in_pins};

    // Independent count of consecutive edges with an unchanged monitored set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_m     <= '0;
            seen      <= 1'b0;
            quiet_run <= '0;
        end else begin
            ref_m <= mon;
            seen  <= 1'b1;
            if (!seen || (mon != ref_m)) begin
                quiet_run <= '0;
            end else if (quiet_run != RMAX) begin
                quiet_run <= quiet_run + 1'b1;
            end
        end
    end

    a_r3_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> (quiet_run >= QLIM));

    a_r3_not_late: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |-> (quiet_run < QLIM));

    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> (out_q == $past(live_out)));

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && $past(sleep)) |-> $stable(out_q));

    a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |-> (out_q == live_out));

    a_r7_wake_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && (mon != $past(mon))) |=> !sleep);

    a_r8_pending_starts: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> wake_pending);

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pending |-> !sleep);

endmodule

bind pd_ctrl pd_ctrl_chk #(
    .N_IN      (N_IN),
    .N_IO      (N_IO),
    .N_FB      (N_FB),
    .N_OUT     (N_OUT),
    .QUIET_CYC (QUIET_CYC),
    .WAKE_CYC  (WAKE_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_pins      (in_pins),
    .io_pins      (io_pins),
    .ext_clk      (ext_clk),
    .fb_sig       (fb_sig),
    .live_out     (live_out),
    .out_q        (out_q),
    .sleep        (sleep),
    .wake_pending (wake_pending)
);

// File: tb/tb_pd_ctrl.sv
module tb_pd_ctrl;

    localparam int CLK_P = 10;
    localparam int NI = 10;
    localparam int NO_IO = 8;
    localparam int NF = 8;
    localparam int NOUT = 8;
    localparam int QC = 4;
    localparam int WC = 3;
    localparam int MW = NI + NO_IO + NF + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NI-1:0]   in_pins = '0;
    logic [NO_IO-1:0] io_pins = '0;
    logic            ext_clk = 1'b0;
    logic [NF-1:0]   fb_sig = '0;
    logic [NOUT-1:0] live_out = 8'h3C;
    logic [NOUT-1:0] out_q;
    logic            sleep;
    logic            wake_pending;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pd_ctrl #(
        .N_IN(NI), .N_IO(NO_IO), .N_FB(NF), .N_OUT(NOUT),
        .QUIET_CYC(QC), .WAKE_CYC(WC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_pins(in_pins), .io_pins(io_pins),
        .ext_clk(ext_clk), .fb_sig(fb_sig), .live_out(live_out),
        .out_q(out_q), .sleep(sleep), .wake_pending(wake_pending)
    );

    // Reference model built from the requirements.
    logic [MW-1:0]   m_prev;
    bit              m_primed;
    int              m_cnt;
    bit              m_sleep;
    logic [NOUT-1:0] m_hold;
    int              m_wake;

    function automatic logic [NOUT-1:0] exp_out(input bit slp,
            input logic [NOUT-1:0] hold, input logic [NOUT-1:0] live);
        return slp ? hold : live;
    endfunction

    function automatic logic [MW-1:0] cur_mon();
        return {fb_sig, io_pins, ext_clk, in_pins};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = '0; m_primed = 0; m_cnt = 0; m_sleep = 0; m_hold = '0; m_wake = 0;
        end else begin
            bit chg;
            int nw;
            chg = m_primed && (cur_mon() != m_prev);
            nw  = (m_wake > 0) ? m_wake - 1 : 0;
            if (m_sleep) begin
                if (chg) begin m_sleep = 0; nw = WC; m_cnt = 0; end
            end else if (!m_primed || chg) begin
                m_cnt = 0;
            end else if (m_cnt == QC - 1) begin
                m_sleep = 1; m_hold = live_out; nw = 0; m_cnt = 0;
            end else begin
                m_cnt++;
            end
            m_prev = cur_mon(); m_primed = 1; m_wake = nw;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            chk("R3 model sleep", {31'd0, sleep}, {31'd0, m_sleep});
            chk("R8 model wake_pending", {31'd0, wake_pending}, {31'd0, (m_wake != 0)});
            chk("R5/R6 model out_q", {24'd0, out_q}, {24'd0, exp_out(m_sleep, m_hold, live_out)});
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic until_sleep();
        for (int i = 0; i < 3 * QC + 4 && !sleep; i++) tick();
    endtask

    task automatic toggle_bit(input int idx);
        if (idx < NI) in_pins[idx] = ~in_pins[idx];
        else if (idx == NI) ext_clk = ~ext_clk;
        else if (idx < NI + 1 + NO_IO) io_pins[idx-NI-1] = ~io_pins[idx-NI-1];
        else fb_sig[idx-NI-1-NO_IO] = ~fb_sig[idx-NI-1-NO_IO];
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R2: reset state
        ticks(3);
        chk("R2 reset sleep", {31'd0, sleep}, 32'd0);
        chk("R2 reset wake_pending", {31'd0, wake_pending}, 32'd0);
        chk("R2 reset out follows live", {24'd0, out_q}, 32'h3C);
        rst_n = 1'b1;
        // R2/R3: priming edge plus QC quiet edges
        ticks(QC);
        chk("R2 priming edge not counted", {31'd0, sleep}, 32'd0);
        tick();
        chk("R3 sleep after quiet interval", {31'd0, sleep}, 32'd1);
        // R5: held value ignores live_out
        live_out = 8'hA5;
        tick();
        chk("R5 hold ignores live_out", {24'd0, out_q}, 32'h3C);
        // R7/R8: wake on input toggle
        toggle_bit(0);
        tick();
        chk("R7 wake on change", {31'd0, sleep}, 32'd0);
        chk("R6 live after wake", {24'd0, out_q}, 32'hA5);
        for (int k = 1; k < WC; k++) begin
            tick();
            chk("R8 pending window", {31'd0, wake_pending}, 32'd1);
        end
        tick();
        chk("R8 pending ends", {31'd0, wake_pending}, 32'd0);
        // R4/R9: late change restarts interval
        ticks(QC - 1 - WC);
        chk("R9 still awake before interval", {31'd0, sleep}, 32'd0);
        toggle_bit(NI + 1 + NO_IO + 3);
        ticks(QC);
        chk("R4 restart delays sleep", {31'd0, sleep}, 32'd0);
        tick();
        chk("R4 sleep after restarted interval", {31'd0, sleep}, 32'd1);
        // R1: each group wakes
        for (int g = 0; g < 4; g++) begin
            int idx;
            until_sleep();
            chk("R1 asleep before group wake", {31'd0, sleep}, 32'd1);
            idx = (g == 0) ? NI - 1 : (g == 1) ? NI : (g == 2) ? NI + NO_IO : MW - 1;
            toggle_bit(idx);
            tick();
            chk("R1 group wakes", {31'd0, sleep}, 32'd0);
        end
        // R10: reset during sleep
        until_sleep();
        live_out = 8'h5A;
        tick();
        rst_n = 1'b0;
        #1;
        chk("R10 reset clears sleep", {31'd0, sleep}, 32'd0);
        chk("R10 out follows live in reset", {24'd0, out_q}, 32'h5A);
        tick();
        rst_n = 1'b1;
        // Random phase
        for (int c = 0; c < 4000; c++) begin
            tick();
            live_out = NOUT'($urandom);
            if (($urandom % 12) == 0) toggle_bit(int'($urandom % MW));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule